// File: doc/BRIEF.md
# Configurable I/O Routing Cell

This block is a single I/O cell of a programmable signal crosspoint. It receives four routed data legs from the routing pool and picks one of them with a 4:1 select. It can pass that value straight to its pad, or hold it in a storage element that acts either as an edge register or as a transparent latch. The same storage element can instead sit on the input side, between the pad input and the feedback line that returns to the routing pool.

Every control line has its own polarity bit: the two select bits, the storage clock, the clock enable and the output enable. Each select bit is taken from one of two select sources. The storage element is clocked either by the dedicated global clock or by a routed clock, and each of these has a matching enable. The pad value can be inverted or forced to a fixed level, which lets the cell stand in for a jumper. An open-drain option drives only lows. The pad enable stays off while the global reset is asserted and for a programmable number of cycles after it is released.

All of the cell's logic runs on the one system clock. When the routed clock is chosen, the cell detects the rising edge of that clock after its polarity is applied.

Top module: `io_route_cell`

## Requirements
- R1: With select bits {s1,s0} (each after source choice and polarity), the value 00 picks leg[0], 01 picks leg[1], 11 picks leg[2] and 10 picks leg[3].
- R2: Select bit s0 comes from muxSelB when cfgMux0FromB=1 and from muxSelA otherwise, and is inverted when cfgMux0Inv=1. Select bit s1 follows the same rules with cfgMux1FromB and cfgMux1Inv.
- R3: With cfgPathB=0, the storage view drives the pad path and fbOut equals padIn in the same cycle.
- R4: With cfgPathB=1, the storage takes padIn and drives fbOut, while the pad path takes the selected leg with no delay.
- R5: In register mode (cfgMode=1) on the global clock, the storage loads on a clock edge only when gClkEn XOR cfgCeInv is 1; otherwise it holds.
- R6: In latch mode (cfgMode=2), the storage view follows its input in the same cycle while the gate is open, and holds the last value once the gate closes. On the global clock the gate is the active enable. On the routed clock the gate is the active routed clock level AND the active routed enable.
- R7: In bypass mode (cfgMode=0), the storage view equals its input combinationally.
- R8: With cfgUseRoutedClk=1 in register mode, the storage loads only on a cycle where rtClk XOR cfgClkInv is 1 and was 0 in the previous cycle, and rtClkEn XOR cfgCeInv is 1.
- R9: While rstN is low the storage reads 0, and this takes effect without waiting for a clock edge.
- R10: With cfgOutInv=1, the pad value is the inverse of the path value.
- R11: With cfgFixedEn=1, the pad value is cfgFixedVal whatever the legs, selects and storage hold.
- R12: With cfgOpenDrain=1, padOut is 0 and padOe is high only when the pad value is 0 and the output enable is active.
- R13: The output enable is active when oeIn XOR cfgOeInv is 1, but padOe stays 0 while rstN is low and for PWRUP_CYCLES clock edges after rstN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also serves as the dedicated global clock |
| rstN | input | 1 | Global reset, active low, asynchronous |
| leg | input | 4 | Four routed data legs feeding the select |
| muxSelA | input | 1 | First select source |
| muxSelB | input | 1 | Second select source |
| gClkEn | input | 1 | Global clock enable |
| rtClk | input | 1 | Routed clock |
| rtClkEn | input | 1 | Routed clock enable |
| oeIn | input | 1 | Routed output enable |
| padIn | input | 1 | Value seen at the pad |
| cfgMux0FromB | input | 1 | Take s0 from muxSelB |
| cfgMux1FromB | input | 1 | Take s1 from muxSelB |
| cfgMux0Inv | input | 1 | Invert s0 |
| cfgMux1Inv | input | 1 | Invert s1 |
| cfgUseRoutedClk | input | 1 | Clock the storage from rtClk/rtClkEn |
| cfgClkInv | input | 1 | Invert the routed clock |
| cfgCeInv | input | 1 | Invert the selected clock enable |
| cfgOeInv | input | 1 | Invert oeIn |
| cfgMode | input | 2 | Storage mode: 0 bypass, 1 register, 2 latch |
| cfgPathB | input | 1 | Place storage on the input path |
| cfgOutInv | input | 1 | Invert the pad value |
| cfgFixedEn | input | 1 | Force the pad value to cfgFixedVal |
| cfgFixedVal | input | 1 | Fixed pad level |
| cfgOpenDrain | input | 1 | Drive only lows |
| padOut | output | 1 | Pad data |
| padOe | output | 1 | Pad drive enable |
| fbOut | output | 1 | Feedback toward the routing pool |

## Verification
One-hot leg patterns are swept through all four select codes. This catches a plain binary decode, because a binary decode swaps the legs picked by 11 and 10. The bench then drives both select sources with opposite values, which shows whether the source choice and the inversion act on each bit separately. The routed clock is driven as a random level stream. This separates true rising-edge loading from loading on the level and from loading on the global clock. Long random runs that change the configuration every few cycles mix path placement, mode, polarities, fixed level and open drain, and each combination is compared against a bench model that carries the storage state from cycle to cycle.

// File: rtl/route_cell_pkg.sv
package route_cell_pkg;
  localparam int NUM_LEGS = 4;
  localparam int SEL_W = $clog2(NUM_LEGS);

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_REG    = 2'd1,
    MODE_LATCH  = 2'd2
  } store_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;         // {s1,s0} after source choice and polarity
    logic             capture;     // storage loads at this clock edge
    logic             transparent; // latch view follows input this cycle
    logic             oeActive;    // output enable, power-up gating applied
  } cell_strobe_t;
endpackage

// File: rtl/route_cell_ctrl.sv
module route_cell_ctrl
  import route_cell_pkg::*;
#(
  parameter int PWRUP_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         muxSelA,
  input  logic         muxSelB,
  input  logic         cfgMux0FromB,
  input  logic         cfgMux1FromB,
  input  logic         cfgMux0Inv,
  input  logic         cfgMux1Inv,
  input  logic         gClkEn,
  input  logic         rtClk,
  input  logic         rtClkEn,
  input  logic         cfgUseRoutedClk,
  input  logic         cfgClkInv,
  input  logic         cfgCeInv,
  input  logic         oeIn,
  input  logic         cfgOeInv,
  input  store_mode_e  cfgMode,
  output cell_strobe_t strobe
);
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(PWRUP_CYCLES);

  logic routedLvl, routedPrev, clkEnAct, edgeTick, latchGate, upDone;
  logic [CNT_W-1:0] upCnt;
  logic [1:0] selSrc, selPol;

  // per-bit source choice and polarity
  assign selSrc = {cfgMux1FromB ? muxSelB : muxSelA, cfgMux0FromB ? muxSelB : muxSelA};
  assign selPol = {cfgMux1Inv, cfgMux0Inv};

  assign routedLvl = rtClk ^ cfgClkInv;
  assign clkEnAct  = (cfgUseRoutedClk ? rtClkEn : gClkEn) ^ cfgCeInv;
  assign edgeTick  = cfgUseRoutedClk ? (routedLvl & ~routedPrev) : 1'b1;
  assign latchGate = cfgUseRoutedClk ? (routedLvl & clkEnAct) : clkEnAct;

  // previous routed level; reset high so a level already high is no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) routedPrev <= 1'b1;
    else       routedPrev <= routedLvl;
  end

  // power-up interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        upCnt <= '0;
    else if (!upDone) upCnt <= upCnt + 1'b1;
  end
  assign upDone = (upCnt == CNT_DONE);

  always_comb begin
    strobe.sel         = selSrc ^ selPol;
    strobe.capture     = 1'b0;
    strobe.transparent = 1'b0;
    unique case (cfgMode)
      MODE_REG:   strobe.capture = edgeTick & clkEnAct;
      MODE_LATCH: begin
        strobe.capture     = latchGate;
        strobe.transparent = latchGate;
      end
      default:    strobe.capture = 1'b0;
    endcase
    strobe.oeActive = (oeIn ^ cfgOeInv) & upDone & rstN;
  end
endmodule

// File: rtl/route_cell_dp.sv
module route_cell_dp
  import route_cell_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LEGS-1:0] leg,
  input  logic                padIn,
  input  cell_strobe_t        strobe,
  input  store_mode_e         cfgMode,
  input  logic                cfgPathB,
  input  logic                cfgOutInv,
  input  logic                cfgFixedEn,
  input  logic                cfgFixedVal,
  input  logic                cfgOpenDrain,
  output logic                padOut,
  output logic                padOe,
  output logic                fbOut
);
  logic muxOut, stD, stQ, stView, corePath, padVal;

  // reflected select code: 00,01,11,10 -> legs 0..3
  always_comb begin
    unique case (strobe.sel)
      2'b00:   muxOut = leg[0];
      2'b01:   muxOut = leg[1];
      2'b11:   muxOut = leg[2];
      default: muxOut = leg[3];
    endcase
  end

  assign stD = cfgPathB ? padIn : muxOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stQ <= 1'b0;
    else if (strobe.capture) stQ <= stD;
  end

  always_comb begin
    unique case (cfgMode)
      MODE_BYPASS: stView = stD;
      MODE_LATCH:  stView = strobe.transparent ? stD : stQ;
      default:     stView = stQ;
    endcase
  end

  assign corePath = cfgPathB ? muxOut : stView;
  assign fbOut    = cfgPathB ? stView : padIn;
  assign padVal   = cfgFixedEn ? cfgFixedVal : (corePath ^ cfgOutInv);
  assign padOut   = cfgOpenDrain ? 1'b0 : padVal;
  assign padOe    = cfgOpenDrain ? (strobe.oeActive & ~padVal) : strobe.oeActive;
endmodule

// File: rtl/io_route_cell.sv
module io_route_cell
  import route_cell_pkg::*;
#(
  parameter int PWRUP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] leg,
  input  logic       muxSelA,
  input  logic       muxSelB,
  input  logic       gClkEn,
  input  logic       rtClk,
  input  logic       rtClkEn,
  input  logic       oeIn,
  input  logic       padIn,
  input  logic       cfgMux0FromB,
  input  logic       cfgMux1FromB,
  input  logic       cfgMux0Inv,
  input  logic       cfgMux1Inv,
  input  logic       cfgUseRoutedClk,
  input  logic       cfgClkInv,
  input  logic       cfgCeInv,
  input  logic       cfgOeInv,
  input  logic [1:0] cfgMode,
  input  logic       cfgPathB,
  input  logic       cfgOutInv,
  input  logic       cfgFixedEn,
  input  logic       cfgFixedVal,
  input  logic       cfgOpenDrain,
  output logic       padOut,
  output logic       padOe,
  output logic       fbOut
);
  cell_strobe_t strobe;
  store_mode_e  modeSel;

  assign modeSel = store_mode_e'(cfgMode);

  route_cell_ctrl #(.PWRUP_CYCLES(PWRUP_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .muxSelA(muxSelA), .muxSelB(muxSelB),
    .cfgMux0FromB(cfgMux0FromB), .cfgMux1FromB(cfgMux1FromB),
    .cfgMux0Inv(cfgMux0Inv), .cfgMux1Inv(cfgMux1Inv),
    .gClkEn(gClkEn), .rtClk(rtClk), .rtClkEn(rtClkEn),
    .cfgUseRoutedClk(cfgUseRoutedClk), .cfgClkInv(cfgClkInv), .cfgCeInv(cfgCeInv),
    .oeIn(oeIn), .cfgOeInv(cfgOeInv), .cfgMode(modeSel), .strobe(strobe)
  );

  route_cell_dp uDp (
    .clk(clk), .rstN(rstN), .leg(leg), .padIn(padIn), .strobe(strobe),
    .cfgMode(modeSel), .cfgPathB(cfgPathB), .cfgOutInv(cfgOutInv),
    .cfgFixedEn(cfgFixedEn), .cfgFixedVal(cfgFixedVal), .cfgOpenDrain(cfgOpenDrain),
    .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );
endmodule

// File: rtl/route_cell_chk.sv
module route_cell_chk #(
  parameter int PWRUP_CYCLES = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       padOut,
  input logic       padOe,
  input logic       padIn,
  input logic       stQ,
  input logic       gClkEn,
  input logic       cfgCeInv,
  input logic       cfgUseRoutedClk,
  input logic [1:0] cfgMode,
  input logic       cfgPathB,
  input logic       cfgFixedEn,
  input logic       cfgFixedVal,
  input logic       cfgOpenDrain
);
  localparam int CW = $clog2(PWRUP_CYCLES + 1);
  logic [CW-1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != CW'(PWRUP_CYCLES)) sinceRst <= sinceRst + 1'b1;
  end

  // R9: storage reads zero whenever reset is held
  assert_reset_clear_R9: assert property (@(posedge clk) !rstN |-> !stQ);

  // R13: no drive during reset or the power-up interval
  assert_pwrup_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != CW'(PWRUP_CYCLES)) |-> !padOe);

  // R12: open drain never drives a high
  assert_od_no_high_R12: assert property (@(posedge clk) disable iff (!rstN)
    cfgOpenDrain |-> (!padOut && !(padOe && (cfgFixedEn && cfgFixedVal))));

  // R11: forced level reaches the pad
  assert_fixed_level_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFixedEn && !cfgOpenDrain) |-> (padOut == cfgFixedVal));

  // R5: enabled global-clock register on input path loads the pad value
  assert_reg_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd1 && cfgPathB && !cfgUseRoutedClk && (gClkEn ^ cfgCeInv))
    |=> (stQ == $past(padIn)));

  // R6: closed latch on global clock holds
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd2 && !cfgUseRoutedClk && !(gClkEn ^ cfgCeInv)) |=> $stable(stQ));
endmodule

bind io_route_cell route_cell_chk #(.PWRUP_CYCLES(PWRUP_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .padOut(padOut), .padOe(padOe), .padIn(padIn),
  .stQ(uDp.stQ), .gClkEn(gClkEn), .cfgCeInv(cfgCeInv),
  .cfgUseRoutedClk(cfgUseRoutedClk), .cfgMode(cfgMode), .cfgPathB(cfgPathB),
  .cfgFixedEn(cfgFixedEn), .cfgFixedVal(cfgFixedVal), .cfgOpenDrain(cfgOpenDrain)
);

// File: tb/sim_io_route_cell.sv
module sim_io_route_cell;
  localparam int PW = 8;

  logic clk = 1'b0, rstN = 1'b1;
  logic [3:0] leg;
  logic muxSelA, muxSelB, gClkEn, rtClk, rtClkEn, oeIn, padIn;
  logic cfgMux0FromB, cfgMux1FromB, cfgMux0Inv, cfgMux1Inv, cfgUseRoutedClk;
  logic cfgClkInv, cfgCeInv, cfgOeInv, cfgPathB, cfgOutInv, cfgFixedEn, cfgFixedVal, cfgOpenDrain;
  logic [1:0] cfgMode;
  logic padOut, padOe, fbOut;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  // bench model state
  logic mQ = 1'b0, mPrev = 1'b1;
  int mCnt = 0;

  always #10 clk = ~clk;

  io_route_cell #(.PWRUP_CYCLES(PW)) u0 (
    .clk(clk), .rstN(rstN), .leg(leg), .muxSelA(muxSelA), .muxSelB(muxSelB),
    .gClkEn(gClkEn), .rtClk(rtClk), .rtClkEn(rtClkEn), .oeIn(oeIn), .padIn(padIn),
    .cfgMux0FromB(cfgMux0FromB), .cfgMux1FromB(cfgMux1FromB),
    .cfgMux0Inv(cfgMux0Inv), .cfgMux1Inv(cfgMux1Inv),
    .cfgUseRoutedClk(cfgUseRoutedClk), .cfgClkInv(cfgClkInv), .cfgCeInv(cfgCeInv),
    .cfgOeInv(cfgOeInv), .cfgMode(cfgMode), .cfgPathB(cfgPathB), .cfgOutInv(cfgOutInv),
    .cfgFixedEn(cfgFixedEn), .cfgFixedVal(cfgFixedVal), .cfgOpenDrain(cfgOpenDrain),
    .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );

  // R1 code table: 00->0, 01->1, 11->2, 10->3
  function automatic logic pickLeg(logic [3:0] l, logic s1, logic s0);
    case ({s1, s0})
      2'b00: return l[0];
      2'b01: return l[1];
      2'b11: return l[2];
      default: return l[3];
    endcase
  endfunction

  task automatic compare(string tag, string what, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // inputs were set at the falling edge; check, then advance the model
  task automatic step(string tag);
    logic s0, s1, sel, lvl, en, tick, gate, d, view, core, val, oeA, expOut, expOe, expFb;
    #1;
    if (!rstN) begin mQ = 1'b0; mPrev = 1'b1; mCnt = 0; end
    s0   = (cfgMux0FromB ? muxSelB : muxSelA) ^ cfgMux0Inv;
    s1   = (cfgMux1FromB ? muxSelB : muxSelA) ^ cfgMux1Inv;
    sel  = pickLeg(leg, s1, s0);
    lvl  = rtClk ^ cfgClkInv;
    en   = (cfgUseRoutedClk ? rtClkEn : gClkEn) ^ cfgCeInv;
    tick = cfgUseRoutedClk ? (lvl && !mPrev) : 1'b1;
    gate = cfgUseRoutedClk ? (lvl && en) : en;
    d    = cfgPathB ? padIn : sel;
    view = (cfgMode == 2'd0) ? d : (cfgMode == 2'd2 && gate) ? d : mQ;
    core = cfgPathB ? sel : view;
    expFb = cfgPathB ? view : padIn;
    val  = cfgFixedEn ? cfgFixedVal : (core ^ cfgOutInv);
    oeA  = (oeIn ^ cfgOeInv) && (mCnt >= PW) && rstN;
    expOut = cfgOpenDrain ? 1'b0 : val;
    expOe  = cfgOpenDrain ? (oeA && !val) : oeA;
    compare(tag, "padOut", padOut, expOut);
    compare(tag, "padOe", padOe, expOe);
    compare(tag, "fbOut", fbOut, expFb);
    if (rstN) begin
      if ((cfgMode == 2'd1 && tick && en) || (cfgMode == 2'd2 && gate)) mQ = d;
      mPrev = lvl;
      if (mCnt < PW) mCnt++;
    end
    @(negedge clk);
  endtask

  task automatic defaults();
    leg = 4'b0000; muxSelA = 0; muxSelB = 0; gClkEn = 1; rtClk = 0; rtClkEn = 1;
    oeIn = 1; padIn = 0; cfgMux0FromB = 0; cfgMux1FromB = 0; cfgMux0Inv = 0;
    cfgMux1Inv = 0; cfgUseRoutedClk = 0; cfgClkInv = 0; cfgCeInv = 0; cfgOeInv = 0;
    cfgMode = 2'd1; cfgPathB = 0; cfgOutInv = 0; cfgFixedEn = 0; cfgFixedVal = 0;
    cfgOpenDrain = 0;
  endtask

  task automatic randData();
    leg = 4'($urandom); muxSelA = 1'($urandom); muxSelB = 1'($urandom);
    gClkEn = 1'($urandom); rtClk = 1'($urandom); rtClkEn = 1'($urandom);
    oeIn = 1'($urandom); padIn = 1'($urandom);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    defaults();
    #2 rstN = 0;
    @(negedge clk);
    // reset state (R9, R13)
    step("R9"); step("R13");
    rstN = 1;
    for (int i = 0; i < PW + 2; i++) step("R13");

    // R1: every select code against one-hot legs, bypass
    cfgMode = 2'd0; cfgMux1FromB = 1;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 4; s++) begin
        leg = 4'(1 << l); muxSelA = s[0]; muxSelB = s[1]; step("R1");
      end
    // R2: source choice and polarity per bit
    for (int i = 0; i < 16; i++) begin
      {cfgMux0FromB, cfgMux1FromB, cfgMux0Inv, cfgMux1Inv} = 4'(i);
      leg = 4'($urandom); muxSelA = 1'($urandom); muxSelB = ~muxSelA; step("R2");
    end
    defaults();
    // R7 bypass
    cfgMode = 2'd0;
    for (int i = 0; i < 8; i++) begin randData(); step("R7"); end
    // R5 register on global clock with enable
    cfgMode = 2'd1;
    for (int i = 0; i < 16; i++) begin randData(); cfgCeInv = i[3]; step("R5"); end
    // R6 latch on both clock sources
    cfgMode = 2'd2;
    for (int i = 0; i < 24; i++) begin randData(); cfgUseRoutedClk = i[4]; step("R6"); end
    // R8 routed clock edges
    cfgMode = 2'd1; cfgUseRoutedClk = 1;
    for (int i = 0; i < 24; i++) begin randData(); cfgClkInv = i[4]; step("R8"); end
    defaults();
    // R3 storage on output path, R4 on input path
    for (int i = 0; i < 8; i++) begin randData(); step("R3"); end
    cfgPathB = 1;
    for (int i = 0; i < 8; i++) begin randData(); step("R4"); end
    // R9: load a one then reset mid-run
    padIn = 1; gClkEn = 1; step("R9");
    step("R9");
    rstN = 0; step("R9"); step("R9");
    rstN = 1;
    for (int i = 0; i < PW + 1; i++) step("R13");
    defaults();
    // R10 output polarity
    cfgOutInv = 1;
    for (int i = 0; i < 6; i++) begin randData(); step("R10"); end
    // R11 fixed level
    cfgFixedEn = 1;
    for (int i = 0; i < 6; i++) begin randData(); cfgFixedVal = i[0]; step("R11"); end
    cfgFixedEn = 0;
    // R12 open drain
    cfgOpenDrain = 1;
    for (int i = 0; i < 8; i++) begin randData(); cfgOutInv = i[2]; step("R12"); end
    defaults();
    // R13 enable polarity
    for (int i = 0; i < 6; i++) begin randData(); cfgOeInv = i[1]; step("R13"); end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 16 == 0) begin
        {cfgMux0FromB, cfgMux1FromB, cfgMux0Inv, cfgMux1Inv} = 4'($urandom);
        {cfgUseRoutedClk, cfgClkInv, cfgCeInv, cfgOeInv, cfgPathB, cfgOutInv} = 6'($urandom);
        cfgMode = 2'($urandom_range(0, 2));
        cfgFixedEn = ($urandom_range(0, 7) == 0); cfgFixedVal = 1'($urandom);
        cfgOpenDrain = ($urandom_range(0, 5) == 0);
      end
      randData();
      step("RND");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule